// File: doc/BRIEF.md
# Plane Latch Register Port

This block holds two banks of per-plane latch bytes for a four-plane pixel engine: a foreground bank and a background bank. A host reaches both banks through a byte-wide register bus with separate write and read strobes, each carrying its own 8-bit index. The foreground planes can be loaded one index per plane. Both banks can also be streamed through a single index each. In streamed mode, a plane pointer selects the byte and moves to the next plane after every write.

A control index loads both plane pointers at once from two separate fields of the data byte. A streamed read returns the byte at the current pointer and then returns that pointer to plane 0. All latch bytes are exported as flat buses. The foreground byte chosen by a two-bit address from the pixel ALU is also presented as a ready operand.

Top module: `plane_latch_port`

## Requirements
- R1: After reset both plane pointers are 0 and every latch byte of both banks is 0x00.
- R2: A write to index 0xEC, 0xED, 0xEE or 0xEF loads foreground plane 0, 1, 2 or 3 with the write data on the next clock edge. No other byte changes.
- R3: A write to index 0xF0 stores the data in the foreground plane selected by the foreground pointer. The pointer then advances by one and wraps from 3 to 0.
- R4: A write to index 0xF2 stores the data in the background plane selected by the background pointer. That pointer then advances by one and wraps from 3 to 0.
- R5: A write to index 0xF1 sets the background pointer to data bits [1:0] and the foreground pointer to data bits [5:4]. The other data bits have no effect, and no latch byte changes.
- R6: While the read strobe is high with index 0xF0, read data shows the foreground plane at the foreground pointer. After that edge the foreground pointer is 0.
- R7: While the read strobe is high with index 0xF2, read data shows the background plane at the background pointer. After that edge the background pointer is 0.
- R8: A read of any other index, and any cycle with the read strobe low, gives read data 0xFF. Such a read changes no pointer and no latch byte.
- R9: A read and a write may occur in the same cycle. The read shows state from before the edge, and a streamed write uses the pointer from before the edge. Each pointer's next value follows this priority: a load from 0xF1 first, then the clear from a streamed read, then the advance from a streamed write.
- R10: Plane p of each bank appears at bits [8p+7:8p] of its export bus. The ALU operand equals the foreground plane selected by the two-bit ALU address.
- R11: Each clock edge with a strobe high performs its effect once, so a strobe held for two cycles acts twice. With both strobes low, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 8 | Write register index |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_idx | input | 8 | Read register index |
| rd_data | output | 8 | Read data, combinational |
| alu_sel | input | 2 | Foreground plane select from the pixel ALU |
| alu_fg_operand | output | 8 | Selected foreground byte |
| fg_bytes | output | 32 | All foreground planes |
| bg_bytes | output | 32 | All background planes |

## Verification
A streamed read and a write can land in the same cycle and compete for one pointer. The cases are a streamed write with a streamed read of the same bank, a pointer load with a streamed read, and a streamed write of one bank with a streamed read of the other. The bench drives these pairs on both strobes in one cycle. It then compares the returned byte, the bank contents and the next pointer, made visible by a later streamed read, against a model that applies the stated priority.

// File: rtl/plane_latch_pkg.sv
package plane_latch_pkg;
   localparam int unsigned IDX_W = 8;
   localparam logic [IDX_W-1:0] IDX_FG_DIRECT = 8'hEC;
   localparam logic [IDX_W-1:0] IDX_FG_STREAM = 8'hF0;
   localparam logic [IDX_W-1:0] IDX_PTR_CTRL  = 8'hF1;
   localparam logic [IDX_W-1:0] IDX_BG_STREAM = 8'hF2;

   typedef struct packed {
      logic fg_stream_we;
      logic bg_stream_we;
      logic ptr_load;
      logic fg_rd;
      logic bg_rd;
   } plane_cmd_t;
endpackage

// File: rtl/plane_cmd_decode.sv
module plane_cmd_decode
   import plane_latch_pkg::*;
#(
   parameter int unsigned PLANES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [PLANES-1:0] direct_we,
   output plane_cmd_t        cmd
);
   for (genvar p = 0; p < PLANES; p++) begin : g_direct
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(int'(IDX_FG_DIRECT) + p);
      assign direct_we[p] = wr_en && (wr_idx == MY_IDX);
   end

   always_comb begin
      cmd.fg_stream_we = wr_en && (wr_idx == IDX_FG_STREAM);
      cmd.bg_stream_we = wr_en && (wr_idx == IDX_BG_STREAM);
      cmd.ptr_load     = wr_en && (wr_idx == IDX_PTR_CTRL);
      cmd.fg_rd        = rd_en && (rd_idx == IDX_FG_STREAM);
      cmd.bg_rd        = rd_en && (rd_idx == IDX_BG_STREAM);
   end

   // R9: one write index hits at most one write action
   p_one_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({direct_we, cmd.fg_stream_we, cmd.bg_stream_we, cmd.ptr_load}));
endmodule

// File: rtl/plane_pointer.sv
module plane_pointer #(
   parameter int unsigned PTR_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PTR_W-1:0] load_val,
   input  logic             clear,
   input  logic             step,
   output logic [PTR_W-1:0] ptr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr <= '0;
      else if (load)  ptr <= load_val;
      else if (clear) ptr <= '0;
      else if (step)  ptr <= ptr + 1'b1;
   end

   p_ptr_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> ptr == $past(load_val));
   p_ptr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !load) |=> ptr == '0);
   p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clear && !load) |=> ptr == PTR_W'($past(ptr) + 1));
   p_ptr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(load || clear || step) |=> $stable(ptr));
endmodule

// File: rtl/plane_latch_bank.sv
module plane_latch_bank #(
   parameter int unsigned PLANES = 4,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned PTR_W = $clog2(PLANES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [PLANES-1:0]        direct_we,
   input  logic                     stream_we,
   input  logic [PTR_W-1:0]         ptr,
   input  logic [DATA_W-1:0]        wdata,
   output logic [PLANES*DATA_W-1:0] bytes_o
);
   for (genvar p = 0; p < PLANES; p++) begin : g_plane
      logic we;
      logic [DATA_W-1:0] q;
      assign we = direct_we[p] || (stream_we && (ptr == PTR_W'(p)));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  q <= '0;
         else if (we) q <= wdata;
      end
      assign bytes_o[p*DATA_W +: DATA_W] = q;

      p_latch_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (direct_we[p] || (stream_we && ptr == PTR_W'(p)))
         |=> bytes_o[p*DATA_W +: DATA_W] == $past(wdata));
      p_latch_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
         !(direct_we[p] || (stream_we && ptr == PTR_W'(p)))
         |=> $stable(bytes_o[p*DATA_W +: DATA_W]));
   end
endmodule

// File: rtl/plane_latch_port.sv
module plane_latch_port
   import plane_latch_pkg::*;
#(
   parameter int unsigned PLANES     = 4,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned FG_PTR_LSB = 4,
   parameter bit          ALU_REG    = 1'b0,
   localparam int unsigned PTR_W     = $clog2(PLANES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     rd_en,
   input  logic [IDX_W-1:0]         rd_idx,
   output logic [DATA_W-1:0]        rd_data,
   input  logic [PTR_W-1:0]         alu_sel,
   output logic [DATA_W-1:0]        alu_fg_operand,
   output logic [PLANES*DATA_W-1:0] fg_bytes,
   output logic [PLANES*DATA_W-1:0] bg_bytes
);
   if (PLANES < 2 || (PLANES & (PLANES - 1)) != 0) begin : g_bad_planes
      $error("PLANES must be a power of two, at least 2");
   end
   if (FG_PTR_LSB < PTR_W || FG_PTR_LSB + PTR_W > DATA_W) begin : g_bad_field
      $error("pointer fields overlap or exceed the data byte");
   end

   plane_cmd_t        cmd;
   logic [PLANES-1:0] direct_we;
   logic [PTR_W-1:0]  fg_ptr, bg_ptr;

   plane_cmd_decode #(.PLANES(PLANES)) i_dec (
      .clk, .rst_n, .wr_en, .wr_idx, .rd_en, .rd_idx,
      .direct_we(direct_we), .cmd(cmd)
   );

   plane_pointer #(.PTR_W(PTR_W)) i_fg_ptr (
      .clk, .rst_n, .load(cmd.ptr_load),
      .load_val(wr_data[FG_PTR_LSB +: PTR_W]),
      .clear(cmd.fg_rd), .step(cmd.fg_stream_we), .ptr(fg_ptr)
   );

   plane_pointer #(.PTR_W(PTR_W)) i_bg_ptr (
      .clk, .rst_n, .load(cmd.ptr_load),
      .load_val(wr_data[PTR_W-1:0]),
      .clear(cmd.bg_rd), .step(cmd.bg_stream_we), .ptr(bg_ptr)
   );

   plane_latch_bank #(.PLANES(PLANES), .DATA_W(DATA_W)) i_fg_bank (
      .clk, .rst_n, .direct_we(direct_we), .stream_we(cmd.fg_stream_we),
      .ptr(fg_ptr), .wdata(wr_data), .bytes_o(fg_bytes)
   );

   plane_latch_bank #(.PLANES(PLANES), .DATA_W(DATA_W)) i_bg_bank (
      .clk, .rst_n, .direct_we('0), .stream_we(cmd.bg_stream_we),
      .ptr(bg_ptr), .wdata(wr_data), .bytes_o(bg_bytes)
   );

   always_comb begin
      if (cmd.fg_rd)      rd_data = fg_bytes[fg_ptr*DATA_W +: DATA_W];
      else if (cmd.bg_rd) rd_data = bg_bytes[bg_ptr*DATA_W +: DATA_W];
      else                rd_data = '1;
   end

   if (ALU_REG) begin : g_alu_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) alu_fg_operand <= '0;
         else        alu_fg_operand <= fg_bytes[alu_sel*DATA_W +: DATA_W];
      end
   end else begin : g_alu_comb
      assign alu_fg_operand = fg_bytes[alu_sel*DATA_W +: DATA_W];
   end

   // R8: an unhandled read with no write leaves both banks untouched
   p_unhandled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && rd_idx != IDX_FG_STREAM && rd_idx != IDX_BG_STREAM)
      |=> $stable(fg_bytes) && $stable(bg_bytes));
endmodule

// File: tb/test_plane_latch_port.sv
module test_plane_latch_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wr_idx = '0, rd_idx = '0, wr_data = '0;
   logic [1:0] alu_sel = '0;
   logic [7:0] rd_data, alu_fg_operand;
   logic [31:0] fg_bytes, bg_bytes;

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";

   // behavioural reference model
   int m_fg[4];
   int m_bg[4];
   int m_fp = 0, m_bp = 0;

   always #4 clk = ~clk;   // 125 MHz

   plane_latch_port i_plane_latch_port (
      .clk, .rst_n, .wr_en, .wr_idx, .wr_data, .rd_en, .rd_idx,
      .rd_data, .alu_sel, .alu_fg_operand, .fg_bytes, .bg_bytes
   );

   task automatic chk(string what, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
      end
   endtask

   function automatic int pack4(int a[4]);
      return (a[3] << 24) | (a[2] << 16) | (a[1] << 8) | a[0];
   endfunction

   // one bus cycle: drive, compare against model, advance model at the edge
   task automatic cyc(bit w, int wi, int wd, bit r, int ri);
      int exp_rd;
      int nfp, nbp;
      @(negedge clk);
      wr_en = w; wr_idx = 8'(wi); wr_data = 8'(wd);
      rd_en = r; rd_idx = 8'(ri);
      alu_sel = 2'(checks);
      #1;
      exp_rd = 'hFF;
      if (r && ri == 'hF0) exp_rd = m_fg[m_fp];
      else if (r && ri == 'hF2) exp_rd = m_bg[m_bp];
      chk("rd_data", int'(rd_data), exp_rd);
      chk("fg_bytes", int'(fg_bytes), pack4(m_fg));
      chk("bg_bytes", int'(bg_bytes), pack4(m_bg));
      chk("alu_fg_operand R10", int'(alu_fg_operand), m_fg[int'(alu_sel)]);
      nfp = m_fp; nbp = m_bp;
      if (w && wi >= 'hEC && wi <= 'hEF) m_fg[wi - 'hEC] = wd & 'hFF;
      if (w && wi == 'hF0) m_fg[m_fp] = wd & 'hFF;
      if (w && wi == 'hF2) m_bg[m_bp] = wd & 'hFF;
      if (w && wi == 'hF1) begin
         nfp = (wd >> 4) & 3; nbp = wd & 3;
      end else begin
         if (r && ri == 'hF0) nfp = 0; else if (w && wi == 'hF0) nfp = (m_fp + 1) % 4;
         if (r && ri == 'hF2) nbp = 0; else if (w && wi == 'hF2) nbp = (m_bp + 1) % 4;
      end
      m_fp = nfp; m_bp = nbp;
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) begin m_fg[i] = 0; m_bg[i] = 0; end
      repeat (3) @(negedge clk);
      cur_req = "R1";
      #1;
      chk("reset fg_bytes", int'(fg_bytes), 0);
      chk("reset bg_bytes", int'(bg_bytes), 0);
      rst_n = 1'b1;
      cyc(0, 0, 0, 1, 'hF0);
      cyc(0, 0, 0, 1, 'hF2);

      cur_req = "R2";
      for (int p = 0; p < 4; p++) cyc(1, 'hEC + p, 'h10 + p * 'h11, 0, 0);

      cur_req = "R8";
      cyc(0, 0, 0, 1, 'hF1);
      cyc(0, 0, 0, 1, 'hEC);
      cyc(0, 0, 0, 1, 'h00);
      cyc(0, 0, 0, 0, 'hF0);

      cur_req = "R3";
      for (int k = 0; k < 6; k++) cyc(1, 'hF0, 'hA0 + k, 0, 0);
      cyc(0, 0, 0, 1, 'hF0);

      cur_req = "R5";
      cyc(1, 'hF1, 'hE6, 0, 0);     // bg=2, fg=2, upper bits ignored
      cyc(0, 0, 0, 1, 'hF0);
      cyc(1, 'hF1, 'h1B, 0, 0);     // bg=3, fg=1

      cur_req = "R4";
      for (int k = 0; k < 5; k++) cyc(1, 'hF2, 'hC0 + k, 0, 0);

      cur_req = "R7";
      cyc(0, 0, 0, 1, 'hF2);
      cyc(0, 0, 0, 1, 'hF2);

      cur_req = "R6";
      cyc(1, 'hF1, 'h30, 0, 0);
      cyc(0, 0, 0, 1, 'hF0);
      cyc(0, 0, 0, 1, 'hF0);

      cur_req = "R11";
      cyc(1, 'hF0, 'h5A, 0, 0);
      cyc(1, 'hF0, 'h5B, 0, 0);
      cyc(0, 0, 0, 0, 0);
      cyc(0, 0, 0, 1, 'hF0);

      cur_req = "R9";
      cyc(1, 'hF1, 'h21, 0, 0);
      cyc(1, 'hF0, 'h77, 1, 'hF0);  // write at old ptr, clear wins
      cyc(0, 0, 0, 1, 'hF0);
      cyc(1, 'hF1, 'h32, 1, 'hF2);  // load wins over clear
      cyc(0, 0, 0, 1, 'hF2);
      cyc(1, 'hF1, 'h11, 0, 0);
      cyc(1, 'hF2, 'h88, 1, 'hF0);  // independent banks
      cyc(0, 0, 0, 1, 'hF2);
      cyc(1, 'hF0, 'h99, 1, 'hF2);
      cyc(0, 0, 0, 1, 'hF0);

      cur_req = "R10";
      for (int k = 0; k < 8; k++) cyc(0, 0, 0, 0, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule